// File: doc/BRIEF.md
# Microcontroller Data-Space to APB3 Bridge

This block sits between a small 8-bit controller's external data-memory port (16-bit address, separate read and write strobes, 8-bit data) and an APB3 fabric that carries up to sixteen peripherals. A fixed 4 KB window at the very top of the 64 KB data space is reserved for peripherals. An access that lands in the window becomes one APB3 transfer to the slave chosen by the address. Every other access is handed on unchanged to an ordinary data-memory port.

Inside the window, the four address bits just below the top nibble pick one of sixteen 256-byte slave slots. The low byte becomes the APB address, so a peripheral's registers sit at byte offsets 0x00, 0x04, 0x08 and so on. For each peripheral access the bridge runs a setup phase and then one or more access phases. It holds the controller in a stall until the chosen slave reports ready. Within that completing cycle it returns the slave's read data. An error response from the chosen slave is kept in a sticky flag that the controller can see on a port.

The controller protocol is as follows. The controller raises `host_rd` or `host_wr` with a stable address and data. It counts the access as done at the first rising edge where `host_stall` is low. It may start a new access in the very next cycle.

Top module: `mcu_apb_bridge`

## Requirements
- R1: After a synchronous active-low reset, all slave selects and `apb_penable` are low, `host_stall` is low while no strobe is raised, and `bus_err` is low.
- R2: An access below 0xF000 never raises a slave select and never stalls. It copies the strobes, address and write data to the memory port in the same cycle, and `host_rdata` equals `mem_rdata`.
- R3: An access in 0xF000..0xFFFF selects exactly slave number addr[11:8], with a one-hot `apb_psel` bit at that index, and drives `apb_paddr` = addr[7:0].
- R4: Each peripheral transfer starts with exactly one setup cycle (select high, `apb_penable` low) in the cycle after the strobe is first seen. The following cycle is an access cycle with `apb_penable` high.
- R5: `host_stall` is high from the first strobe cycle of a peripheral access. It stays high until the access cycle in which the selected slave's ready is high, and it is low in that cycle.
- R6: A write drives `apb_pwrite`=1 and `apb_pwdata` = write data. A read drives `apb_pwrite`=0, and in the completing cycle `host_rdata` equals the selected slave's read-data byte.
- R7: While the selected slave holds ready low in an access cycle, address, select, direction and write data stay unchanged. Ready and error inputs of unselected slaves have no effect.
- R8: An error input that is high together with ready in the completing cycle of the selected slave sets `bus_err` from the next cycle on. It stays set until reset. Error inputs seen while ready is low, or on unselected slaves, leave `bus_err` low.
- R9: In the cycle after a completing access cycle, all selects and `apb_penable` are low again, and the bridge is ready for a new access.
- R10: The memory-port strobes stay low during a peripheral access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 16 | Controller data-space address |
| host_rd | input | 1 | Controller read strobe |
| host_wr | input | 1 | Controller write strobe |
| host_wdata | input | 8 | Controller write data |
| host_rdata | output | 8 | Read data returned to controller |
| host_stall | output | 1 | Holds the controller until the access completes |
| mem_addr | output | 16 | Address to ordinary data memory |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| apb_paddr | output | 8 | APB address (offset inside the slave slot) |
| apb_psel | output | 16 | One-hot slave selects |
| apb_penable | output | 1 | APB enable (access phase) |
| apb_pwrite | output | 1 | APB direction, 1 = write |
| apb_pwdata | output | 8 | APB write data |
| apb_prdata | input | 128 | Slave read data, slave n at bits [8n+7:8n] |
| apb_pready | input | 16 | Per-slave ready |
| apb_pslverr | input | 16 | Per-slave error |
| bus_err | output | 1 | Sticky transfer-error flag |

## Verification
A wrong slot register or decode shows up within two cycles of the strobe as a select bit at the wrong index, or as read data from a slave other than the one addressed. A wrong phase state shows in the same cycle as a missing setup cycle, an early stall release, or a select that lingers after completion. The bench sweeps every slot with several offsets, both directions and zero to two wait states. It also sweeps memory addresses on both sides of the window edge and drives error inputs that must and must not set the flag, which exposes a bad sticky register one cycle after the completing edge.

// File: rtl/mab_pkg.sv
// Shared types for the data-space to APB3 bridge.
package mab_pkg;
    // Phase of the peripheral transfer sequencer.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } phase_t;
endpackage

// File: rtl/mab_window_decode.sv
// Address window decoder.
// Splits a controller address into a window hit flag, a slave slot index
// and an offset within the slot. Assumes the window is the topmost block
// of the data space whose upper bits are all ones.
module mab_window_decode #(
    parameter int ADDR_W  = 16,
    parameter int OFFS_W  = 8,
    parameter int SLOT_W  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [SLOT_W-1:0] slot,
    output logic [OFFS_W-1:0] offs
);
    localparam int TOP_W = ADDR_W - OFFS_W - SLOT_W;

    // Decode the three address fields.
    always_comb begin
        hit  = &addr[ADDR_W-1 -: TOP_W];
        slot = addr[OFFS_W +: SLOT_W];
        offs = addr[OFFS_W-1:0];
    end
endmodule

// File: rtl/mab_resp_mux.sv
// Slave response selector.
// Picks ready, read data and error of the slave whose index is given.
// Assumes an index beyond the fitted slave count reads as a ready slave
// with zero data and no error, so a stray access cannot hang the master.
module mab_resp_mux #(
    parameter int NUM_SLV = 16,
    parameter int DATA_W  = 8,
    parameter int SLOT_W  = 4
) (
    input  logic [SLOT_W-1:0]          sel_idx,
    input  logic [NUM_SLV*DATA_W-1:0]  prdata_all,
    input  logic [NUM_SLV-1:0]         pready_all,
    input  logic [NUM_SLV-1:0]         pslverr_all,
    output logic [DATA_W-1:0]          prdata_sel,
    output logic                       pready_sel,
    output logic                       pslverr_sel
);
    // Select the addressed slave's response lines.
    always_comb begin
        prdata_sel  = '0;
        pready_sel  = 1'b1;
        pslverr_sel = 1'b0;
        for (int s = 0; s < NUM_SLV; s++) begin
            if (int'(sel_idx) == s) begin
                prdata_sel  = prdata_all[s*DATA_W +: DATA_W];
                pready_sel  = pready_all[s];
                pslverr_sel = pslverr_all[s];
            end
        end
    end
endmodule

// File: rtl/mab_xfer_ctrl.sv
// APB3 transfer sequencer.
// Runs idle -> setup -> access (repeated until ready) for one peripheral
// request, registers address, direction, data and slot at the start,
// raises the stall toward the master and keeps a sticky error flag.
// Assumes the master holds address, strobe and data while stalled.
module mab_xfer_ctrl
    import mab_pkg::*;
#(
    parameter int NUM_SLV = 16,
    parameter int DATA_W  = 8,
    parameter int OFFS_W  = 8,
    parameter int SLOT_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               req_wr,
    input  logic [SLOT_W-1:0]  req_slot,
    input  logic [OFFS_W-1:0]  req_offs,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic               pready_sel,
    input  logic               pslverr_sel,
    output logic [SLOT_W-1:0]  slot_q,
    output logic [OFFS_W-1:0]  paddr,
    output logic [NUM_SLV-1:0] psel,
    output logic               penable,
    output logic               pwrite,
    output logic [DATA_W-1:0]  pwdata,
    output logic               stall,
    output logic               done,
    output logic               err_flag
);
    phase_t phase_q, phase_d;

    // Next-phase logic of the transfer sequence.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:   if (req) phase_d = PH_SETUP;
            PH_SETUP:  phase_d = PH_ACCESS;
            PH_ACCESS: if (pready_sel) phase_d = PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Capture the request fields when a transfer starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            paddr  <= '0;
            pwrite <= 1'b0;
            pwdata <= '0;
        end else if (phase_q == PH_IDLE && req) begin
            slot_q <= req_slot;
            paddr  <= req_offs;
            pwrite <= req_wr;
            pwdata <= req_wdata;
        end
    end

    // Completion, enable and stall toward the master.
    always_comb begin
        done    = (phase_q == PH_ACCESS) && pready_sel;
        penable = (phase_q == PH_ACCESS);
        stall   = req && !done;
    end

    // One select line per slave slot.
    for (genvar g = 0; g < NUM_SLV; g++) begin : g_sel
        assign psel[g] = (phase_q != PH_IDLE) && (int'(slot_q) == g);
    end

    // Sticky error capture on a completing transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                    err_flag <= 1'b0;
        else if (done && pslverr_sel)  err_flag <= 1'b1;
    end

    a_r4_setup_then_access: assert property (@(posedge clk) disable iff (!rst_n)
        (|psel && !penable) |=> (penable && |psel));
    a_r4_enable_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
        penable |-> |psel);
    a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(psel));
    a_r7_hold_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (penable && !pready_sel) |=> ($stable(paddr) && $stable(psel) && $stable(pwrite) && $stable(pwdata)));
    a_r5_stall_while_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (penable && !pready_sel && req) |-> stall);
    a_r9_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !penable);
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
endmodule

// File: rtl/mcu_apb_bridge.sv
// Data-space to APB3 bridge (top).
// Routes controller accesses in the top window of the data space to an
// APB3 fabric of up to NUM_SLV slaves and all others to the memory port.
// Assumes one master that holds its strobe, address and data while stalled.
module mcu_apb_bridge #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int OFFS_W  = 8,
    parameter int NUM_SLV = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic                       host_rd,
    input  logic                       host_wr,
    input  logic [DATA_W-1:0]          host_wdata,
    output logic [DATA_W-1:0]          host_rdata,
    output logic                       host_stall,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic                       mem_rd,
    output logic                       mem_wr,
    output logic [DATA_W-1:0]          mem_wdata,
    input  logic [DATA_W-1:0]          mem_rdata,
    output logic [OFFS_W-1:0]          apb_paddr,
    output logic [NUM_SLV-1:0]         apb_psel,
    output logic                       apb_penable,
    output logic                       apb_pwrite,
    output logic [DATA_W-1:0]          apb_pwdata,
    input  logic [NUM_SLV*DATA_W-1:0]  apb_prdata,
    input  logic [NUM_SLV-1:0]         apb_pready,
    input  logic [NUM_SLV-1:0]         apb_pslverr,
    output logic                       bus_err
);
    localparam int SLOT_W = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1;

    logic              win_hit;
    logic [SLOT_W-1:0] win_slot;
    logic [OFFS_W-1:0] win_offs;
    logic [SLOT_W-1:0] cur_slot;
    logic [DATA_W-1:0] sel_rdata;
    logic              sel_ready;
    logic              sel_err;
    logic              apb_req;
    logic              xfer_done;

    mab_window_decode #(
        .ADDR_W (ADDR_W),
        .OFFS_W (OFFS_W),
        .SLOT_W (SLOT_W)
    ) decode_i (
        .addr (host_addr),
        .hit  (win_hit),
        .slot (win_slot),
        .offs (win_offs)
    );

    // A peripheral request is any strobe inside the window.
    always_comb apb_req = (host_rd || host_wr) && win_hit;

    mab_resp_mux #(
        .NUM_SLV (NUM_SLV),
        .DATA_W  (DATA_W),
        .SLOT_W  (SLOT_W)
    ) resp_i (
        .sel_idx     (cur_slot),
        .prdata_all  (apb_prdata),
        .pready_all  (apb_pready),
        .pslverr_all (apb_pslverr),
        .prdata_sel  (sel_rdata),
        .pready_sel  (sel_ready),
        .pslverr_sel (sel_err)
    );

    mab_xfer_ctrl #(
        .NUM_SLV (NUM_SLV),
        .DATA_W  (DATA_W),
        .OFFS_W  (OFFS_W),
        .SLOT_W  (SLOT_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (apb_req),
        .req_wr      (host_wr),
        .req_slot    (win_slot),
        .req_offs    (win_offs),
        .req_wdata   (host_wdata),
        .pready_sel  (sel_ready),
        .pslverr_sel (sel_err),
        .slot_q      (cur_slot),
        .paddr       (apb_paddr),
        .psel        (apb_psel),
        .penable     (apb_penable),
        .pwrite      (apb_pwrite),
        .pwdata      (apb_pwdata),
        .stall       (host_stall),
        .done        (xfer_done),
        .err_flag    (bus_err)
    );

    // Memory pass-through for addresses outside the window.
    always_comb begin
        mem_addr  = host_addr;
        mem_wdata = host_wdata;
        mem_rd    = host_rd && !win_hit;
        mem_wr    = host_wr && !win_hit;
    end

    // Return data: slave byte inside the window, memory byte elsewhere.
    always_comb host_rdata = win_hit ? sel_rdata : mem_rdata;

    a_r2_no_sel_outside: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_rd || host_wr) && !win_hit) |-> (apb_psel == '0 && !host_stall));
    a_r10_mem_quiet_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (|apb_psel) |-> (!mem_rd && !mem_wr));
    a_r5_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !host_stall);
endmodule

// File: tb/mcu_apb_bridge_tb_top.sv
// Sweep bench for the data-space to APB3 bridge.
module mcu_apb_bridge_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [15:0]  host_addr = '0;
    logic         host_rd = 1'b0;
    logic         host_wr = 1'b0;
    logic [7:0]   host_wdata = '0;
    logic [7:0]   host_rdata;
    logic         host_stall;
    logic [15:0]  mem_addr;
    logic         mem_rd, mem_wr;
    logic [7:0]   mem_wdata;
    logic [7:0]   mem_rdata;
    logic [7:0]   apb_paddr;
    logic [15:0]  apb_psel;
    logic         apb_penable, apb_pwrite;
    logic [7:0]   apb_pwdata;
    logic [127:0] apb_prdata;
    logic [15:0]  apb_pready;
    logic [15:0]  apb_pslverr;
    logic         bus_err;

    int checks = 0;
    int errors = 0;
    int wait_cfg = 0;
    int err_mode = 0;
    int acc_cnt = 0;

    always #10 clk = ~clk;

    mcu_apb_bridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_stall(host_stall),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .apb_paddr(apb_paddr), .apb_psel(apb_psel), .apb_penable(apb_penable),
        .apb_pwrite(apb_pwrite), .apb_pwdata(apb_pwdata), .apb_prdata(apb_prdata),
        .apb_pready(apb_pready), .apb_pslverr(apb_pslverr), .bus_err(bus_err)
    );

    // Slave models: data = slot<<4 ^ offset ^ 0xA5; ready after wait_cfg access cycles.
    always_ff @(posedge clk) begin
        if (apb_penable && acc_cnt != wait_cfg) acc_cnt <= acc_cnt + 1;
        else acc_cnt <= 0;
    end
    always_comb begin
        for (int s = 0; s < 16; s++)
            apb_prdata[s*8 +: 8] = (8'(s) << 4) ^ apb_paddr ^ 8'hA5;
        apb_pready = {16{apb_penable && acc_cnt == wait_cfg}};
        case (err_mode)
            1: apb_pslverr = ~apb_psel;
            2: apb_pslverr = apb_psel & {16{apb_penable && acc_cnt != wait_cfg}};
            3: apb_pslverr = apb_psel & {16{apb_penable && acc_cnt == wait_cfg}};
            default: apb_pslverr = '0;
        endcase
        mem_rdata = mem_addr[7:0] ^ mem_addr[15:8];
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One peripheral access with full cycle-by-cycle checks.
    task automatic apb_access(input logic [15:0] addr, input bit wr, input logic [7:0] wd,
                              input int waits, input int emode);
        int slot = int'(addr[11:8]);
        @(negedge clk);
        wait_cfg = waits; err_mode = emode;
        host_addr = addr; host_wr = wr; host_rd = !wr; host_wdata = wd;
        #2;
        check("R5 stall first cycle", 32'(host_stall), 32'd1);
        check("R4 no select before setup", 32'(apb_psel), 32'd0);
        check("R10 mem strobes low", 32'({mem_rd, mem_wr}), 32'd0);
        @(negedge clk); #2;
        check("R3 one-hot select", 32'(apb_psel), 32'(16'd1 << slot));
        check("R3 paddr", 32'(apb_paddr), 32'(addr[7:0]));
        check("R4 setup enable low", 32'(apb_penable), 32'd0);
        check("R6 direction", 32'(apb_pwrite), 32'(wr));
        if (wr) check("R6 pwdata", 32'(apb_pwdata), 32'(wd));
        check("R5 stall in setup", 32'(host_stall), 32'd1);
        for (int k = 0; k <= waits; k++) begin
            @(negedge clk); #2;
            check("R4 access enable", 32'(apb_penable), 32'd1);
            check("R7 select held", 32'(apb_psel), 32'(16'd1 << slot));
            check("R7 paddr held", 32'(apb_paddr), 32'(addr[7:0]));
            if (k < waits) check("R5 stall while waiting", 32'(host_stall), 32'd1);
            else begin
                check("R5 stall released", 32'(host_stall), 32'd0);
                if (!wr) check("R6 read data", 32'(host_rdata),
                               32'((8'(slot) << 4) ^ addr[7:0] ^ 8'hA5));
            end
        end
        @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0; err_mode = 0;
        #2;
        check("R9 idle after done", 32'({apb_psel, apb_penable}), 32'd0);
    endtask

    // One memory-port access.
    task automatic mem_access(input logic [15:0] addr, input bit wr, input logic [7:0] wd);
        @(negedge clk);
        host_addr = addr; host_wr = wr; host_rd = !wr; host_wdata = wd;
        #2;
        check("R2 no select", 32'(apb_psel), 32'd0);
        check("R2 no stall", 32'(host_stall), 32'd0);
        check("R2 mem strobes", 32'({mem_rd, mem_wr}), 32'({!wr, wr}));
        check("R2 mem addr", 32'(mem_addr), 32'(addr));
        if (wr) check("R2 mem wdata", 32'(mem_wdata), 32'(wd));
        else check("R2 read data", 32'(host_rdata), 32'(addr[7:0] ^ addr[15:8]));
        @(negedge clk); #2;
        check("R2 still no select", 32'({apb_psel, apb_penable}), 32'd0);
        host_rd = 1'b0; host_wr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [7:0] offs [4] = '{8'h00, 8'h04, 8'h0C, 8'hFF};
        repeat (3) @(negedge clk);
        #2;
        check("R1 reset selects", 32'({apb_psel, apb_penable}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk); #2;
        check("R1 idle stall", 32'(host_stall), 32'd0);
        check("R1 err clear", 32'(bus_err), 32'd0);
        check("R1 idle selects", 32'({apb_psel, apb_penable}), 32'd0);

        // Memory side, including both sides of the window edge.
        mem_access(16'h0000, 1'b0, 8'h00);
        mem_access(16'h1234, 1'b1, 8'h3C);
        mem_access(16'hEFFF, 1'b0, 8'h00);
        mem_access(16'h8001, 1'b1, 8'hC3);

        // Every slot, several offsets, both directions, 0..2 waits.
        for (int s = 0; s < 16; s++)
            for (int o = 0; o < 4; o++) begin
                apb_access({4'hF, 4'(s), offs[o]}, 1'b1, 8'(s * 17 + o), (s + o) % 3, 0);
                apb_access({4'hF, 4'(s), offs[o]}, 1'b0, 8'h00, (s + 2 * o) % 3, 0);
            end
        apb_access(16'hF000, 1'b1, 8'h2E, 0, 0);
        check("R8 no error yet", 32'(bus_err), 32'd0);

        // Error inputs that must be ignored.
        apb_access(16'hF304, 1'b0, 8'h00, 2, 1);
        check("R8 unselected error ignored", 32'(bus_err), 32'd0);
        apb_access(16'hF708, 1'b1, 8'h11, 2, 2);
        check("R8 error without ready ignored", 32'(bus_err), 32'd0);

        // Error at completion sets the sticky flag.
        apb_access(16'hFA10, 1'b1, 8'h55, 1, 3);
        check("R8 error captured", 32'(bus_err), 32'd1);
        apb_access(16'hF020, 1'b0, 8'h00, 0, 0);
        mem_access(16'h0100, 1'b0, 8'h00);
        check("R8 error sticky", 32'(bus_err), 32'd1);

        // Back-to-back window accesses then reset clears the flag.
        apb_access(16'hFFFF, 1'b0, 8'h00, 0, 0);
        apb_access(16'hFE00, 1'b1, 8'h99, 0, 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R1 reset clears error", 32'(bus_err), 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule